// File: doc/BRIEF.md
# Linked-List Command DMA Walker

This block follows a chain of command packets held in a 2 MB word-addressed memory and streams their contents to a downstream command consumer. Each packet starts with one header word. The top byte of the header is the number of payload words, which may be zero. The low 24 bits are the address of the next packet. The payload words sit in the memory words directly after the header. A caller gives a start address and pulses `start`. The walker then fetches headers and payload words one read at a time and hands each payload word to the consumer over a valid/ready handshake. It follows the next pointers until it reaches an address with bit 23 set.

While it walks, the block adds up a cost estimate. Each packet costs 10 cycles, and a packet with a nonzero count costs 5 plus the count on top of that. A node counter guards against lists that loop back on themselves. If `NODE_LIMIT` packets have been consumed and the next pointer is still not an end marker, the walk stops and `guard_err` is raised. The block never writes to memory. When a walk ends, `done` pulses for one cycle and the final cost is valid on `cost` during that pulse.

The controller is a state machine with eight states:
- IDLE waits for `start`.
- HDR_REQ issues the header read.
- HDR_WAIT takes the header word.
- PL_REQ issues a payload read.
- PL_WAIT takes the payload word.
- PL_SEND presents the word to the consumer.
- NODE_END chooses between the next packet, a normal finish and a guard finish.
- FINISH pulses `done`.

The transitions are:
- IDLE→HDR_REQ on a start with a live address.
- IDLE→FINISH on a start with an address that is already terminated.
- HDR_REQ→HDR_WAIT.
- HDR_WAIT→PL_REQ on a nonzero count.
- HDR_WAIT→NODE_END on a zero count.
- PL_REQ→PL_WAIT.
- PL_WAIT→PL_SEND on read data.
- PL_SEND→PL_REQ on an accepted word with words still left.
- PL_SEND→NODE_END on the last word.
- NODE_END→HDR_REQ to follow the pointer.
- NODE_END→FINISH on an end marker or on the guard limit.
- FINISH→IDLE.

Top module: `dma_list_walker`

## Requirements
- R1: The start address is taken modulo 2^24. If bit 23 of the result is set, the walk ends with a `done` pulse, a cost of 0 and no memory read.
- R2: A header word gives the payload count in bits 31:24 and the next packet address in bits 23:0. The header is read at the current packet address.
- R3: Every memory read address is the packet or payload address ANDed with 0x1FFFFF, with bits 1:0 forced to zero. Payload word i (counted from 1) of a packet at address A is read at (A + 4·i) masked the same way, so the addresses wrap within the 2 MB space.
- R4: The payload words of all packets reach the consumer in list order, each exactly once. A packet with count 0 sends nothing.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` holds its value and no memory read is issued.
- R6: The walk ends after the packet whose next pointer has bit 23 set. `done` is high for exactly one cycle, and `busy` is low in the cycle after it.
- R7: During the `done` pulse, `cost` equals the sum over visited packets of 10, plus (5 + count) for each packet with a nonzero count.
- R8: If `NODE_LIMIT` packets have been consumed and the next pointer lacks bit 23, the walk ends with `guard_err` high during `done`. An exactly `NODE_LIMIT`-long terminated list ends without error. `guard_err` clears at the next accepted start.
- R9: A `start` pulse while `busy` is high has no effect on the walk in progress.
- R10: At most one read is outstanding. `mem_rd` is high for single cycles, and no new read is issued before the previous `mem_rvalid`.
- R11: After reset, `busy`, `done`, `out_valid`, `mem_rd` and `guard_err` are low and `cost` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| start_addr | input | 32 | First packet address (reduced to 24 bits) |
| mem_rd | output | 1 | Memory read request, one cycle |
| mem_addr | output | 21 | Byte address of the read, word aligned |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| out_valid | output | 1 | Payload word available |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Consumer accepts the payload word |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| cost | output | 32 | Accumulated cycle-cost estimate |
| guard_err | output | 1 | Walk ended on the node-count guard |

## Verification
The bench goes after several corner cases:
- A start address that is already terminated. A walker that read memory here, or left a stale cost, would issue a read the model does not expect.
- A next pointer with bits 22:21 set, and a packet straddling the top of the 2 MB space. An address that is masked wrongly, or that does not wrap, shows up as a wrong read address.
- Zero-count packets next to a 255-word packet. An error in the count or in the cost formula changes the final cost.
- A self-looping list, and a terminated list exactly `NODE_LIMIT` packets long. An off-by-one guard fails one of the two.
- Heavy consumer stalls and a stray start in mid-walk. A walker that dropped or repeated words, changed data under a stall, or restarted would break the expected payload order.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

    localparam int WORD_W   = 32;
    localparam int PTR_W    = 24;
    localparam int MEM_AW   = 21;
    localparam int LEN_W    = 8;
    localparam int TERM_BIT = PTR_W - 1;
    localparam int WIDX_W   = MEM_AW - 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_REQ,
        ST_HDR_WAIT,
        ST_PL_REQ,
        ST_PL_WAIT,
        ST_PL_SEND,
        ST_NODE_END,
        ST_FINISH
    } walk_state_e;

endpackage

// File: rtl/dlw_cost_acc.sv
module dlw_cost_acc #(
    parameter int COST_W    = 32,
    parameter int LEN_W     = 8,
    parameter int NODE_BASE = 10,
    parameter int LEN_EXTRA = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [LEN_W-1:0]  len,
    output logic [COST_W-1:0] acc
);

    logic [COST_W-1:0] node_cost;

    always_comb begin
        node_cost = COST_W'(NODE_BASE);
        if (len != '0)
            node_cost = node_cost + COST_W'(LEN_EXTRA) + COST_W'(len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= '0;
        else if (add)
            acc <= acc + node_cost;
    end

    // R7: every node adds at least the base cost
    assert_cost_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !clr) |=> (acc >= COST_W'(NODE_BASE)));

endmodule

// File: rtl/dlw_node_guard.sv
module dlw_node_guard #(
    parameter int NODE_LIMIT = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    localparam int CW = $clog2(NODE_LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == CW'(NODE_LIMIT));

    // R8: the controller never consumes a node beyond the limit
    assert_guard_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !at_limit);

endmodule

// File: rtl/dlw_ctrl.sv
module dlw_ctrl
    import dlw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [31:0]        start_addr,
    output logic               mem_rd,
    output logic [MEM_AW-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               out_valid,
    output logic [WORD_W-1:0]  out_data,
    input  logic               out_ready,
    output logic               busy,
    output logic               done,
    output logic               guard_err,
    output logic               acct_clr,
    output logic               acct_add,
    output logic [LEN_W-1:0]   acct_len,
    input  logic               at_limit
);

    walk_state_e state_q, state_d;

    logic [WIDX_W-1:0] cur_q;
    logic [WIDX_W-1:0] pos_q;
    logic [WIDX_W-1:0] nxt_q;
    logic              nxt_term_q;
    logic [LEN_W-1:0]  left_q;
    logic [WORD_W-1:0] data_q;
    logic              err_q;

    logic [LEN_W-1:0]  hdr_len;
    logic              hdr_term;
    logic [WIDX_W-1:0] hdr_nxt;
    logic              unused_bits;

    assign hdr_len     = mem_rdata[WORD_W-1 -: LEN_W];
    assign hdr_term    = mem_rdata[TERM_BIT];
    assign hdr_nxt     = mem_rdata[MEM_AW-1:2];
    assign unused_bits = ^{start_addr[31:PTR_W], start_addr[TERM_BIT-1:MEM_AW],
                           start_addr[1:0], mem_rdata[TERM_BIT-1:MEM_AW],
                           mem_rdata[1:0]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (start)
                    state_d = start_addr[TERM_BIT] ? ST_FINISH : ST_HDR_REQ;
            ST_HDR_REQ:
                state_d = ST_HDR_WAIT;
            ST_HDR_WAIT:
                if (mem_rvalid)
                    state_d = (hdr_len == '0) ? ST_NODE_END : ST_PL_REQ;
            ST_PL_REQ:
                state_d = ST_PL_WAIT;
            ST_PL_WAIT:
                if (mem_rvalid)
                    state_d = ST_PL_SEND;
            ST_PL_SEND:
                if (out_ready)
                    state_d = (left_q == LEN_W'(1)) ? ST_NODE_END : ST_PL_REQ;
            ST_NODE_END:
                state_d = (nxt_term_q || at_limit) ? ST_FINISH : ST_HDR_REQ;
            ST_FINISH:
                state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            pos_q      <= '0;
            nxt_q      <= '0;
            nxt_term_q <= 1'b0;
            left_q     <= '0;
            data_q     <= '0;
            err_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE:
                    if (start) begin
                        cur_q <= start_addr[MEM_AW-1:2];
                        err_q <= 1'b0;
                    end
                ST_HDR_WAIT:
                    if (mem_rvalid) begin
                        nxt_q      <= hdr_nxt;
                        nxt_term_q <= hdr_term;
                        left_q     <= hdr_len;
                        pos_q      <= cur_q + 1'b1;
                    end
                ST_PL_WAIT:
                    if (mem_rvalid)
                        data_q <= mem_rdata;
                ST_PL_SEND:
                    if (out_ready) begin
                        left_q <= left_q - 1'b1;
                        pos_q  <= pos_q + 1'b1;
                    end
                ST_NODE_END:
                    if (!nxt_term_q) begin
                        if (at_limit)
                            err_q <= 1'b1;
                        else
                            cur_q <= nxt_q;
                    end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd    = 1'b0;
        mem_addr  = {cur_q, 2'b00};
        out_valid = 1'b0;
        done      = 1'b0;
        acct_clr  = 1'b0;
        acct_add  = 1'b0;
        unique case (state_q)
            ST_IDLE:     acct_clr = start;
            ST_HDR_REQ:  mem_rd = 1'b1;
            ST_HDR_WAIT: acct_add = mem_rvalid;
            ST_PL_REQ: begin
                mem_rd   = 1'b1;
                mem_addr = {pos_q, 2'b00};
            end
            ST_PL_SEND:  out_valid = 1'b1;
            ST_FINISH:   done = 1'b1;
            default: ;
        endcase
    end

    assign acct_len  = hdr_len;
    assign out_data  = data_q;
    assign busy      = (state_q != ST_IDLE);
    assign guard_err = err_q ^ (unused_bits & 1'b0);

    // R6: done is a single-cycle pulse
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: a stalled word is held
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && !mem_rd));

    // R10: read requests are single cycles
    assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R8: the guard flag appears together with the end of a walk
    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(guard_err) |-> done);

endmodule

// File: rtl/dma_list_walker.sv
module dma_list_walker #(
    parameter int NODE_LIMIT = 8192,
    parameter int COST_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       start_addr,
    output logic              mem_rd,
    output logic [20:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    output logic [31:0]       out_data,
    input  logic              out_ready,
    output logic              busy,
    output logic              done,
    output logic [COST_W-1:0] cost,
    output logic              guard_err
);

    import dlw_pkg::*;

    logic             acct_clr;
    logic             acct_add;
    logic [LEN_W-1:0] acct_len;
    logic             at_limit;

    dlw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_ready  (out_ready),
        .busy       (busy),
        .done       (done),
        .guard_err  (guard_err),
        .acct_clr   (acct_clr),
        .acct_add   (acct_add),
        .acct_len   (acct_len),
        .at_limit   (at_limit)
    );

    dlw_cost_acc #(
        .COST_W (COST_W),
        .LEN_W  (LEN_W)
    ) u_cost (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acct_clr),
        .add   (acct_add),
        .len   (acct_len),
        .acc   (cost)
    );

    dlw_node_guard #(
        .NODE_LIMIT (NODE_LIMIT)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (acct_clr),
        .inc      (acct_add),
        .at_limit (at_limit)
    );

endmodule

// File: tb/test_dma_list_walker.sv
module test_dma_list_walker;

    localparam int LIMIT = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        mem_rd;
    logic [20:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b0;
    logic        busy;
    logic        done;
    logic [31:0] cost;
    logic        guard_err;

    always #5 clk = ~clk;

    dma_list_walker #(.NODE_LIMIT(LIMIT)) i_dma_list_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .busy(busy), .done(done), .cost(cost),
        .guard_err(guard_err)
    );

    logic [31:0] mem [int];
    int          exp_rd[$];
    logic [31:0] exp_pl[$];
    int          exp_cost;
    bit          exp_err;
    int          vectors = 0;
    int          miscompares = 0;
    int          ready_mode = 0;
    bit          armed = 0;
    bit          done_seen = 0;
    bit          prev_stall = 0;
    bit          prev_done = 0;
    logic [31:0] prev_data = '0;
    bit          pend = 0;
    int          pend_lat = 0;
    int          pend_addr = 0;
    int          cycles = 0;

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] rdw(int a);
        int k = (a & 'h1FFFFF) >> 2;
        return mem.exists(k) ? mem[k] : 32'h0;
    endfunction

    task automatic wr(int a, logic [31:0] v);
        mem[(a & 'h1FFFFF) >> 2] = v;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // behavioural reference: list walk over the bench memory
    task automatic model(logic [31:0] sa);
        logic [23:0] a;
        int nodes = 0;
        a = sa[23:0];
        exp_cost = 0;
        exp_err = 0;
        exp_rd.delete();
        exp_pl.delete();
        while (!a[23]) begin
            logic [31:0] h;
            int c;
            if (nodes == LIMIT) begin
                exp_err = 1;
                break;
            end
            exp_rd.push_back(int'(a) & 'h1FFFFC);
            h = rdw(int'(a));
            c = int'(h[31:24]);
            exp_cost += 10 + ((c != 0) ? 5 + c : 0);
            for (int i = 1; i <= c; i++) begin
                int pa = (int'(a) + 4 * i) & 'h1FFFFC;
                exp_rd.push_back(pa);
                exp_pl.push_back(rdw(pa));
            end
            nodes++;
            a = h[23:0];
        end
    endtask

    // per-cycle monitor, memory responder and consumer
    initial begin
        forever begin
            bit new_ready;
            bit had_pend;
            @(negedge clk);
            cycles++;
            if (cycles > 190000) begin
                miscompares++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                summary();
                $finish;
            end
            if (armed) begin
                if (prev_stall)
                    check(out_valid && !mem_rd && out_data == prev_data, "R5",
                          "stalled word", out_data, prev_data);
                if (prev_done)
                    check(!done && !busy, "R6", "done/busy after pulse",
                          {done, busy}, 0);
                if (done) begin
                    done_seen = 1;
                    check(cost == exp_cost, "R7", "final cost", cost, exp_cost);
                    check(guard_err == exp_err, "R8", "guard flag", guard_err, exp_err);
                    check(exp_rd.size() == 0 && exp_pl.size() == 0, "R4",
                          "unconsumed reads/words", exp_rd.size() + exp_pl.size(), 0);
                end
                had_pend = pend;
                mem_rvalid = 1'b0;
                if (pend) begin
                    pend_lat--;
                    if (pend_lat == 0) begin
                        mem_rvalid = 1'b1;
                        mem_rdata = rdw(pend_addr);
                        pend = 0;
                    end
                end
                if (mem_rd) begin
                    check(!had_pend, "R10", "read while outstanding", had_pend, 0);
                    if (exp_rd.size() == 0)
                        check(0, "R3", "unexpected read", mem_addr, 0);
                    else
                        check(int'(mem_addr) == exp_rd[0], "R3", "read address",
                              mem_addr, exp_rd[0]);
                    if (exp_rd.size() != 0) void'(exp_rd.pop_front());
                    pend = 1;
                    pend_lat = 1 + int'($urandom % 3);
                    pend_addr = int'(mem_addr);
                end
                case (ready_mode)
                    0: new_ready = 1'b1;
                    1: new_ready = ($urandom % 2) == 0;
                    default: new_ready = ($urandom % 4) == 0;
                endcase
                out_ready = new_ready;
                if (out_valid && new_ready) begin
                    if (exp_pl.size() == 0)
                        check(0, "R4", "unexpected payload", out_data, 0);
                    else begin
                        check(out_data == exp_pl[0], "R4", "payload word",
                              out_data, exp_pl[0]);
                        void'(exp_pl.pop_front());
                    end
                end
                prev_stall = out_valid && !new_ready;
                prev_data = out_data;
                prev_done = done;
            end
        end
    end

    task automatic run(logic [31:0] sa, int mode, bit stray);
        int t = 0;
        model(sa);
        ready_mode = mode;
        done_seen = 0;
        @(negedge clk);
        start_addr = sa;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done_seen && t < 60000) begin
            @(negedge clk);
            t++;
            if (stray && t == 6 && busy) begin
                // R9: stray start mid-walk must be ignored
                start_addr = 32'h0000_0F00;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        check(done_seen, "R6", "walk completion", done_seen, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic build_basic();
        mem.delete();
        wr('h100, 32'h0300_0200);
        wr('h104, 32'hA1A1_0001);
        wr('h108, 32'hA1A1_0002);
        wr('h10C, 32'hA1A1_0003);
        wr('h200, 32'h0060_0300);   // count 0, next with bits 22:21 set (R3)
        wr('h300, 32'h02FF_FFFF);   // count 2, next terminated (R6)
        wr('h304, 32'hB2B2_0001);
        wr('h308, 32'hB2B2_0002);
        wr('hF00, 32'h01FF_FFFF);   // stray target, must never be read (R9)
        wr('hF04, 32'hDEAD_BEEF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!busy && !done && !out_valid && !mem_rd && !guard_err && cost == 0,
              "R11", "reset outputs", {busy, done, out_valid, mem_rd, guard_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && cost == 0, "R11", "idle after reset", busy, 0);
        armed = 1;

        // R1: terminated start address (upper bits ignored)
        mem.delete();
        run(32'h5580_0000, 0, 0);

        // R1 R2 R3: masked start address, zero-count node, masked pointer
        build_basic();
        run(32'hFF00_0100, 0, 0);
        check(exp_cost == 45, "R7", "model cost of basic list", exp_cost, 45);

        // R5 R9: random stalls and a stray start
        run(32'h0000_0100, 1, 1);

        // R3: payload wrapping past the top of memory, heavy stalls
        mem.delete();
        wr('h1FFFF8, 32'h0380_0000);
        wr('h1FFFFC, 32'hC0C0_0001);
        wr('h000000, 32'hC0C0_0002);
        wr('h000004, 32'hC0C0_0003);
        run(32'h001F_FFF8, 2, 0);

        // R4 R7: mixed counts including 255
        begin
            int cnts[6] = '{1, 255, 0, 7, 2, 4};
            mem.delete();
            for (int n = 0; n < 6; n++) begin
                int base = 'h4000 + n * 'h1000;
                int nxt = (n == 5) ? 'hA12345 : 'h4000 + (n + 1) * 'h1000;
                wr(base, {cnts[n][7:0], nxt[23:0]});
                for (int i = 1; i <= cnts[n]; i++) wr(base + 4 * i, $urandom);
            end
            run(32'h0000_4000, 1, 0);
        end

        // R8: self-looping list trips the guard
        mem.delete();
        wr('h800, 32'h0000_0800);
        run(32'h0000_0800, 0, 0);
        check(exp_cost == 10 * LIMIT, "R8", "model guard cost", exp_cost, 10 * LIMIT);

        // R8: flag clears on the next start
        build_basic();
        run(32'h0000_0100, 0, 0);

        // R8: list exactly LIMIT nodes long, terminated, no error
        mem.delete();
        for (int i = 0; i < LIMIT; i++)
            wr('h10000 + 4 * i, (i == LIMIT - 1) ? 32'h0080_0000 : 32'h0001_0000 + 4 * (i + 1));
        run(32'h0001_0000, 0, 0);

        summary();
        $finish;
    end

endmodule